// File: doc/BRIEF.md
# Colour-Steered Bank Crossbar for Parallel Soft-Decision Decoding

This block sits between several parallel soft-in/soft-out processing engines and a bank of small RAMs that hold per-stage soft values. The contents are laid out by graph colouring: a stage's value lives in the bank whose number equals the stage's precomputed colour, at an offset equal to the stage index modulo the per-engine segment length. Each engine owns a colour table. It indexes the table with its access order (natural or interleaved) and its step within the segment, and the colour it reads back picks the bank for that cycle's request.

Every engine may issue one read and one write per cycle. Reads are steered to one bank and return one cycle later through a selector that is driven by the delayed colour. Writes pass through their own one-cycle alignment register before they reach the bank, so reads and writes proceed side by side. Each engine is wired only to a prefix of the banks, its reach. A learning mode makes every engine consult its neighbour's table. Colours are loaded from outside through a table write port. When a correct colouring is loaded, no two engines address one bank in one cycle; any such clash is flagged.

Top module: `snet_xbar`

## Requirements
- R1: After synchronous active-low reset, `rd_valid`, `clash` and `range_err` are all low.
- R2: A cycle with `tbl_we` high stores `tbl_color` in the table of engine `tbl_port` at entry `tbl_addr`. Entry address bit 3 is the order bit (0 natural, 1 interleaved) and bits 2:0 are the step.
- R3: A write from engine p goes to the bank whose number is the colour read from p's table at {order, step}, at offset `wr_ofs`. The bank is updated two clock edges after the request. A read issued in the cycle after the write returns the old value, and a read issued one cycle later returns the new one.
- R4: An accepted read raises `rd_valid` for that engine exactly one cycle after the request, with `rd_data` holding the addressed bank word. `rd_valid` is low in every other cycle.
- R5: All engines may read and write in the same cycle. Requests that map to distinct banks do not interfere, and `clash` stays low.
- R6: The order bit selects the table half, so the same step with a different order bit can reach a different bank.
- R7: While `learn` is high, engine p uses the colour table of engine (p+1) mod NPORT instead of its own.
- R8: Engine p reaches banks 0 to REACH_p-1; the defaults are 3, 4, 5 and 6 for engines 0 to 3. A request whose colour is outside that range is dropped: no bank is written, `rd_valid` stays low, and `range_err` is high in the next cycle.
- R9: When two accepted reads, or two accepted writes, target one bank in the same cycle, `clash` is high in the next cycle. The lowest-numbered engine's request is the one served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| learn | input | 1 | Static mode: use neighbour's colour table |
| tbl_we | input | 1 | Colour table write strobe |
| tbl_port | input | PW | Engine whose table is written |
| tbl_addr | input | TA_W | Table entry {order, step} |
| tbl_color | input | COL_W | Colour to store |
| rd_req | input | NPORT | Read request per engine |
| rd_ord | input | NPORT | Read order bit per engine |
| rd_step | input | NPORT*OFS_W | Read step per engine (table index) |
| rd_ofs | input | NPORT*OFS_W | Read bank offset per engine |
| rd_valid | output | NPORT | Read data valid per engine |
| rd_data | output | NPORT*DATA_W | Read data per engine |
| wr_req | input | NPORT | Write request per engine |
| wr_ord | input | NPORT | Write order bit per engine |
| wr_step | input | NPORT*OFS_W | Write step per engine |
| wr_ofs | input | NPORT*OFS_W | Write bank offset per engine |
| wr_data | input | NPORT*DATA_W | Write data per engine |
| clash | output | 1 | Two requests of one kind hit one bank last cycle |
| range_err | output | 1 | A request fell outside its engine's reach last cycle |

## Verification
The assertions assume that the request inputs are defined and idle from time zero, and that `learn` changes only while no request is in flight. Under those assumptions a raised `rd_valid`, `clash` or `range_err` can always be traced back to the requests of the previous cycle. The stimulus changes inputs only on the falling edge and holds `learn` steady around every request. It uses a loaded colouring in which simultaneous requests collide only in the two directed clash cases.

// File: rtl/snet_pkg.sv
// Shared helpers for the colour-steered bank crossbar.
// Assumes nothing beyond elaboration-time integer arguments.
package snet_pkg;
    // Width of each per-engine reach field in the REACH parameter
    localparam int REACH_FW = 4;

    // Index width that never collapses to zero bits
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/snet_color_tbl.sv
// Per-engine colour table: one write port, two combinational read ports
// (one for the read request, one for the write request).
// Assumes the loader writes only while the engine is idle.
module snet_color_tbl #(
    parameter int TA_W  = 4,
    parameter int COL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [TA_W-1:0]  waddr,
    input  logic [COL_W-1:0] wcol,
    input  logic [TA_W-1:0]  ra_a,
    input  logic [TA_W-1:0]  ra_b,
    output logic [COL_W-1:0] col_a,
    output logic [COL_W-1:0] col_b
);
    localparam int ENTRIES = 2 ** TA_W;

    logic [COL_W-1:0] ent [ENTRIES];

    // Clear on reset, store a colour on a load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
        end else if (we) begin
            ent[waddr] <= wcol;
        end
    end

    assign col_a = ent[ra_a];
    assign col_b = ent[ra_b];
endmodule

// File: rtl/snet_bank.sv
// One RAM bank: synchronous read with one cycle latency, synchronous write.
// A read and a write to the same offset in one cycle return the old word.
// Assumes the crossbar presents at most one read and one write per cycle.
module snet_bank #(
    parameter int DEPTH  = 8,
    parameter int OFS_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              re,
    input  logic [OFS_W-1:0]  raddr,
    input  logic              we,
    input  logic [OFS_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Read-before-write storage array
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/snet_ret_sel.sv
// Return selector for one engine: picks the word of the bank named by the
// delayed colour. Only the first REACH_P banks are wired to this engine.
// Assumes sel arrives aligned with the bank read latency.
module snet_ret_sel #(
    parameter int NBANK   = 6,
    parameter int COL_W   = 3,
    parameter int DATA_W  = 8,
    parameter int REACH_P = 6
) (
    input  logic [NBANK*DATA_W-1:0] bank_q,
    input  logic [COL_W-1:0]        sel,
    output logic [DATA_W-1:0]       data
);
    // Mux over the banks this engine can reach
    always_comb begin
        data = '0;
        for (int b = 0; b < REACH_P; b++) begin
            if (sel == COL_W'(b)) data = bank_q[b*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/snet_xbar.sv
// Colour-steered crossbar between NPORT decoding engines and NBANK RAM
// banks. Each request is steered to the bank named by the engine's colour
// table entry {order, step}; reads return after one cycle through a
// selector driven by the delayed colour; writes are aligned by one register.
// Assumes a conflict-free colouring; clashes are flagged, not arbitrated
// beyond "lowest engine wins". learn is static while requests are in flight.
module snet_xbar
    import snet_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int NBANK  = 6,
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter logic [NPORT*REACH_FW-1:0] REACH = {4'd6, 4'd5, 4'd4, 4'd3},
    localparam int OFS_W = idx_w(DEPTH),
    localparam int COL_W = idx_w(NBANK),
    localparam int TA_W  = OFS_W + 1,
    localparam int PW    = idx_w(NPORT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    learn,
    input  logic                    tbl_we,
    input  logic [PW-1:0]           tbl_port,
    input  logic [TA_W-1:0]         tbl_addr,
    input  logic [COL_W-1:0]        tbl_color,
    input  logic [NPORT-1:0]        rd_req,
    input  logic [NPORT-1:0]        rd_ord,
    input  logic [NPORT*OFS_W-1:0]  rd_step,
    input  logic [NPORT*OFS_W-1:0]  rd_ofs,
    output logic [NPORT-1:0]        rd_valid,
    output logic [NPORT*DATA_W-1:0] rd_data,
    input  logic [NPORT-1:0]        wr_req,
    input  logic [NPORT-1:0]        wr_ord,
    input  logic [NPORT*OFS_W-1:0]  wr_step,
    input  logic [NPORT*OFS_W-1:0]  wr_ofs,
    input  logic [NPORT*DATA_W-1:0] wr_data,
    output logic                    clash,
    output logic                    range_err
);
    // Colours straight out of each table, and colours as used per engine
    logic [NPORT*COL_W-1:0] tcr_f, tcw_f;
    logic [NPORT*COL_W-1:0] rcol_f, wcol_f;
    // Engine-by-bank steering (one-hot per engine when accepted)
    logic [NPORT*NBANK-1:0] rhit_f, whit_f;
    logic [NPORT-1:0]       rout, wout, rd_ok;
    logic [NBANK-1:0]       clash_b;
    // Alignment registers
    logic [NPORT*NBANK-1:0]  wp_hit_f;
    logic [NPORT*OFS_W-1:0]  wp_ofs;
    logic [NPORT*DATA_W-1:0] wp_dat;
    logic [NPORT*COL_W-1:0]  rsel_q;
    logic [NBANK*DATA_W-1:0] bank_q;

    // ---------------- colour tables ----------------
    for (genvar t = 0; t < NPORT; t++) begin : g_tbl
        localparam int PREV = (t + NPORT - 1) % NPORT;
        logic [TA_W-1:0] ta_r, ta_w;

        // In learning mode the table is consulted by the previous engine
        always_comb begin
            if (learn) begin
                ta_r = {rd_ord[PREV], rd_step[PREV*OFS_W +: OFS_W]};
                ta_w = {wr_ord[PREV], wr_step[PREV*OFS_W +: OFS_W]};
            end else begin
                ta_r = {rd_ord[t], rd_step[t*OFS_W +: OFS_W]};
                ta_w = {wr_ord[t], wr_step[t*OFS_W +: OFS_W]};
            end
        end

        snet_color_tbl #(.TA_W(TA_W), .COL_W(COL_W)) u_tbl (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (tbl_we && (tbl_port == PW'(t))),
            .waddr (tbl_addr),
            .wcol  (tbl_color),
            .ra_a  (ta_r),
            .ra_b  (ta_w),
            .col_a (tcr_f[t*COL_W +: COL_W]),
            .col_b (tcw_f[t*COL_W +: COL_W])
        );
    end

    // ---------------- per-engine steering ----------------
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int NEXT = (p + 1) % NPORT;
        localparam int RP   = int'(REACH[p*REACH_FW +: REACH_FW]);
        localparam logic [COL_W:0] RPV = (COL_W+1)'(RP);

        assign rcol_f[p*COL_W +: COL_W] = learn ? tcr_f[NEXT*COL_W +: COL_W]
                                                : tcr_f[p*COL_W +: COL_W];
        assign wcol_f[p*COL_W +: COL_W] = learn ? tcw_f[NEXT*COL_W +: COL_W]
                                                : tcw_f[p*COL_W +: COL_W];

        assign rout[p]  = rd_req[p] && ({1'b0, rcol_f[p*COL_W +: COL_W]} >= RPV);
        assign wout[p]  = wr_req[p] && ({1'b0, wcol_f[p*COL_W +: COL_W]} >= RPV);
        assign rd_ok[p] = rd_req[p] && !rout[p];

        for (genvar b = 0; b < NBANK; b++) begin : g_hit
            if (b < RP) begin : g_wired
                assign rhit_f[p*NBANK+b] = rd_req[p] &&
                    (rcol_f[p*COL_W +: COL_W] == COL_W'(b));
                assign whit_f[p*NBANK+b] = wr_req[p] &&
                    (wcol_f[p*COL_W +: COL_W] == COL_W'(b));
            end else begin : g_open
                assign rhit_f[p*NBANK+b] = 1'b0;
                assign whit_f[p*NBANK+b] = 1'b0;
            end
        end

        snet_ret_sel #(
            .NBANK(NBANK), .COL_W(COL_W), .DATA_W(DATA_W), .REACH_P(RP)
        ) u_sel (
            .bank_q (bank_q),
            .sel    (rsel_q[p*COL_W +: COL_W]),
            .data   (rd_data[p*DATA_W +: DATA_W])
        );
    end

    // ---------------- banks ----------------
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [NPORT-1:0]  rcolv, wcolv, wpcolv;
        logic              b_re, b_we;
        logic [OFS_W-1:0]  b_ra, b_wa;
        logic [DATA_W-1:0] b_wd;

        // Gather which engines target this bank
        always_comb begin
            for (int p = 0; p < NPORT; p++) begin
                rcolv[p]  = rhit_f[p*NBANK+b];
                wcolv[p]  = whit_f[p*NBANK+b];
                wpcolv[p] = wp_hit_f[p*NBANK+b];
            end
        end

        // Request mux: scanned high to low so the lowest engine wins
        always_comb begin
            b_re = 1'b0; b_ra = '0;
            b_we = 1'b0; b_wa = '0; b_wd = '0;
            for (int p = NPORT - 1; p >= 0; p--) begin
                if (rcolv[p]) begin
                    b_re = 1'b1;
                    b_ra = rd_ofs[p*OFS_W +: OFS_W];
                end
                if (wpcolv[p]) begin
                    b_we = 1'b1;
                    b_wa = wp_ofs[p*OFS_W +: OFS_W];
                    b_wd = wp_dat[p*DATA_W +: DATA_W];
                end
            end
        end

        assign clash_b[b] = ($countones(rcolv) > 1) || ($countones(wcolv) > 1);

        snet_bank #(.DEPTH(DEPTH), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .re    (b_re),
            .raddr (b_ra),
            .we    (b_we),
            .waddr (b_wa),
            .wdata (b_wd),
            .rdata (bank_q[b*DATA_W +: DATA_W])
        );
    end

    // Alignment delays, valid return and error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_hit_f  <= '0;
            wp_ofs    <= '0;
            wp_dat    <= '0;
            rsel_q    <= '0;
            rd_valid  <= '0;
            clash     <= 1'b0;
            range_err <= 1'b0;
        end else begin
            wp_hit_f  <= whit_f;
            wp_ofs    <= wr_ofs;
            wp_dat    <= wr_data;
            rsel_q    <= rcol_f;
            rd_valid  <= rd_ok;
            clash     <= |clash_b;
            range_err <= |(rout | wout);
        end
    end
endmodule

// File: rtl/snet_xbar_chk.sv
// Assertion checker for the crossbar, attached by bind. Sees only ports.
// Assumes request inputs are defined from time zero.
module snet_xbar_chk #(
    parameter int NPORT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPORT-1:0] rd_req,
    input logic [NPORT-1:0] wr_req,
    input logic [NPORT-1:0] rd_valid,
    input logic             clash,
    input logic             range_err
);
    // R4
    rd_valid_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_valid & ~$past(rd_req)) == '0));

    // R4
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_req) == '0) |-> (rd_valid == '0));

    // R8
    range_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> ($past(|rd_req) || $past(|wr_req)));

    // R9
    clash_needs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clash |-> (($past($countones(rd_req)) > 1) || ($past($countones(wr_req)) > 1)));
endmodule

bind snet_xbar snet_xbar_chk #(.NPORT(NPORT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .rd_valid  (rd_valid),
    .clash     (clash),
    .range_err (range_err)
);

// File: tb/snet_xbar_test.sv
module snet_xbar_test;
    localparam int NPORT = 4, NBANK = 6, DEPTH = 8, DATA_W = 8;
    localparam int OFS_W = 3, COL_W = 3, TA_W = 4, PW = 2;
    localparam int REACH_N [NPORT] = '{3, 4, 5, 6};

    typedef struct packed {
        logic [1:0] wp; logic wo; logic [2:0] ws; logic [2:0] wofs;
        logic [7:0] dat; logic [1:0] rp; logic ro; logic [2:0] rs;
    } vec_t;

    // write engine/order/step/offset/data, then read engine/order/step (same offset, same bank)
    localparam vec_t VEC [6] = '{
        '{2'd0, 1'b0, 3'd0, 3'd1, 8'h11, 2'd3, 1'b0, 3'd3},
        '{2'd1, 1'b0, 3'd0, 3'd2, 8'h22, 2'd2, 1'b0, 3'd4},
        '{2'd2, 1'b1, 3'd1, 3'd3, 8'h33, 2'd0, 1'b0, 3'd0},
        '{2'd3, 1'b1, 3'd0, 3'd4, 8'h44, 2'd3, 1'b0, 3'd2},
        '{2'd1, 1'b1, 3'd5, 3'd5, 8'h55, 2'd0, 1'b1, 3'd1},
        '{2'd0, 1'b1, 3'd7, 3'd6, 8'h66, 2'd2, 1'b0, 3'd3}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                    rst_n = 1'b0, learn = 1'b0, tbl_we = 1'b0;
    logic [PW-1:0]           tbl_port = '0;
    logic [TA_W-1:0]         tbl_addr = '0;
    logic [COL_W-1:0]        tbl_color = '0;
    logic [NPORT-1:0]        rd_req = '0, rd_ord = '0, wr_req = '0, wr_ord = '0;
    logic [NPORT*OFS_W-1:0]  rd_step = '0, rd_ofs = '0, wr_step = '0, wr_ofs = '0;
    logic [NPORT*DATA_W-1:0] wr_data = '0;
    logic [NPORT-1:0]        rd_valid;
    logic [NPORT*DATA_W-1:0] rd_data;
    logic                    clash, range_err;

    snet_xbar uut (
        .clk(clk), .rst_n(rst_n), .learn(learn), .tbl_we(tbl_we),
        .tbl_port(tbl_port), .tbl_addr(tbl_addr), .tbl_color(tbl_color),
        .rd_req(rd_req), .rd_ord(rd_ord), .rd_step(rd_step), .rd_ofs(rd_ofs),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_req(wr_req), .wr_ord(wr_ord), .wr_step(wr_step), .wr_ofs(wr_ofs),
        .wr_data(wr_data), .clash(clash), .range_err(range_err)
    );

    int total = 0, bad = 0;
    int tbl_m [NPORT][16];
    int mem_m [NBANK][DEPTH];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int mcol(input int p, input bit o, input int s);
        int t = learn ? (p + 1) % NPORT : p;
        return tbl_m[t][(int'(o) << 3) + s];
    endfunction

    task automatic load(input int p, input int a, input int c);
        @(negedge clk);
        tbl_we = 1'b1; tbl_port = PW'(p); tbl_addr = TA_W'(a); tbl_color = COL_W'(c);
        @(negedge clk);
        tbl_we = 1'b0;
        tbl_m[p][a] = c;
    endtask

    task automatic set_wr(input int p, input bit o, input int s, input int ofs, input int d);
        wr_req[p] = 1'b1; wr_ord[p] = o;
        wr_step[p*OFS_W +: OFS_W] = OFS_W'(s);
        wr_ofs[p*OFS_W +: OFS_W]  = OFS_W'(ofs);
        wr_data[p*DATA_W +: DATA_W] = DATA_W'(d);
    endtask

    task automatic set_rd(input int p, input bit o, input int s, input int ofs);
        rd_req[p] = 1'b1; rd_ord[p] = o;
        rd_step[p*OFS_W +: OFS_W] = OFS_W'(s);
        rd_ofs[p*OFS_W +: OFS_W]  = OFS_W'(ofs);
    endtask

    // Single write, then one idle cycle so the bank is updated
    task automatic wr1(input int p, input bit o, input int s, input int ofs, input int d);
        int c;
        @(negedge clk);
        set_wr(p, o, s, ofs, d);
        c = mcol(p, o, s);
        @(negedge clk);
        wr_req = '0;
        if (c < REACH_N[p]) mem_m[c][ofs] = d;
        @(negedge clk);
    endtask

    // Single read; returns valid and data seen one cycle after the request
    task automatic rd1(input int p, input bit o, input int s, input int ofs,
                       output bit v, output int d);
        @(negedge clk);
        set_rd(p, o, s, ofs);
        @(negedge clk);
        rd_req = '0;
        v = rd_valid[p];
        d = int'(rd_data[p*DATA_W +: DATA_W]);
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit v;
        int d, c, oldv;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rd_valid == '0, "R1 rd_valid", int'(rd_valid), 0);
        check(clash == 1'b0, "R1 clash", int'(clash), 0);
        check(range_err == 1'b0, "R1 range_err", int'(range_err), 0);
        rst_n = 1'b1;

        // R2 load tables: colour = (p + step + 2*order) mod reach
        for (int p = 0; p < NPORT; p++)
            for (int a = 0; a < 16; a++)
                load(p, a, (p + (a % 8) + 2 * (a / 8)) % REACH_N[p]);
        load(0, 7, 5);  // out of reach for engine 0

        // R3 / R2 vector walk
        for (int i = 0; i < 6; i++) begin
            wr1(int'(VEC[i].wp), VEC[i].wo, int'(VEC[i].ws), int'(VEC[i].wofs), int'(VEC[i].dat));
            rd1(int'(VEC[i].rp), VEC[i].ro, int'(VEC[i].rs), int'(VEC[i].wofs), v, d);
            c = mcol(int'(VEC[i].rp), VEC[i].ro, int'(VEC[i].rs));
            check(v == 1'b1, "R3 vector valid", int'(v), 1);
            check(d == mem_m[c][VEC[i].wofs], "R3 vector data", d, mem_m[c][VEC[i].wofs]);
        end

        // R6 order bit picks the table half (engine 0 step 1: colour 1 vs 0)
        wr1(0, 1'b0, 1, 0, 8'h77);
        wr1(0, 1'b1, 1, 0, 8'h88);
        rd1(1, 1'b0, 0, 0, v, d);
        check(d == 8'h77, "R6 natural half", d, 8'h77);
        rd1(0, 1'b0, 0, 0, v, d);
        check(d == 8'h88, "R6 interleaved half", d, 8'h88);

        // R3 read right after write returns old, one later returns new
        oldv = mem_m[0][1];
        @(negedge clk);
        set_wr(0, 1'b0, 0, 1, 8'h99);
        @(negedge clk);
        wr_req = '0;
        set_rd(3, 1'b0, 3, 1);
        @(negedge clk);
        rd_req = '0;
        check(rd_data[3*DATA_W +: DATA_W] == DATA_W'(oldv), "R3 old word",
              int'(rd_data[3*DATA_W +: DATA_W]), oldv);
        mem_m[0][1] = 8'h99;
        rd1(3, 1'b0, 3, 1, v, d);
        check(d == 8'h99, "R3 new word", d, 8'h99);

        // R5 all engines write and read together, distinct banks
        @(negedge clk);
        for (int p = 0; p < NPORT; p++) set_wr(p, 1'b0, 0, 7, 8'hA0 + p);
        @(negedge clk);
        wr_req = '0;
        check(clash == 1'b0, "R5 no write clash", int'(clash), 0);
        for (int p = 0; p < NPORT; p++) mem_m[mcol(p, 1'b0, 0)][7] = 8'hA0 + p;
        @(negedge clk);
        for (int p = 0; p < NPORT; p++) set_rd(p, 1'b0, 0, 7);
        @(negedge clk);
        rd_req = '0;
        check(clash == 1'b0, "R5 no read clash", int'(clash), 0);
        for (int p = 0; p < NPORT; p++) begin
            check(rd_valid[p] == 1'b1, "R5 valid", int'(rd_valid[p]), 1);
            check(rd_data[p*DATA_W +: DATA_W] == DATA_W'(8'hA0 + p), "R5 data",
                  int'(rd_data[p*DATA_W +: DATA_W]), 8'hA0 + p);
        end

        // R4 valid lasts exactly one cycle
        rd1(2, 1'b0, 0, 7, v, d);
        check(v == 1'b1, "R4 valid after one cycle", int'(v), 1);
        @(negedge clk);
        check(rd_valid == '0, "R4 valid drops", int'(rd_valid), 0);

        // R8 out-of-reach write dropped, read dropped
        wr1(3, 1'b0, 2, 5, 8'h5A);
        @(negedge clk);
        set_wr(0, 1'b0, 7, 5, 8'hFF);
        @(negedge clk);
        wr_req = '0;
        check(range_err == 1'b1, "R8 write range_err", int'(range_err), 1);
        @(negedge clk);
        rd1(3, 1'b0, 2, 5, v, d);
        check(d == 8'h5A, "R8 bank untouched", d, 8'h5A);
        rd1(0, 1'b0, 7, 5, v, d);
        check(v == 1'b0, "R8 read dropped", int'(v), 0);
        check(range_err == 1'b1, "R8 read range_err", int'(range_err), 1);

        // R9 two writes to bank 0 (engines 0 and 1, step 3)
        @(negedge clk);
        set_wr(0, 1'b0, 3, 6, 8'hC1);
        set_wr(1, 1'b0, 3, 6, 8'hC2);
        @(negedge clk);
        wr_req = '0;
        check(clash == 1'b1, "R9 write clash", int'(clash), 1);
        @(negedge clk);
        check(clash == 1'b0, "R9 clash clears", int'(clash), 0);
        rd1(0, 1'b0, 3, 6, v, d);
        check(d == 8'hC1, "R9 lowest engine wins", d, 8'hC1);
        @(negedge clk);
        set_rd(0, 1'b0, 3, 6);
        set_rd(1, 1'b0, 3, 6);
        @(negedge clk);
        rd_req = '0;
        check(clash == 1'b1, "R9 read clash", int'(clash), 1);

        // R7 learning mode: engine 1 uses engine 2's table (bank 2, not 1)
        @(negedge clk);
        learn = 1'b1;
        c = mcol(1, 1'b0, 0);
        rd1(1, 1'b0, 0, 7, v, d);
        check(d == mem_m[c][7], "R7 neighbour table", d, mem_m[c][7]);
        check(d == 8'hA2, "R7 bank of neighbour", d, 8'hA2);
        @(negedge clk);
        learn = 1'b0;
        rd1(1, 1'b0, 0, 7, v, d);
        check(d == 8'hA1, "R7 own table again", d, 8'hA1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule